// File: doc/BRIEF.md
# Multi-Frame Serial Peripheral Interface Master

This block is the shift engine of a serial peripheral interface master. It moves one to four data frames, each 8 to 32 bits long, in a single chip-select window. All frames of a transfer are loaded with one wide write, and that write starts the transfer. Each transfer carries its own settings, which are latched when the write is accepted: clock polarity and phase, frame length, frame count, bit order, bit-rate divider, target chip select, direction, and the two delays at the end of the transfer.

The serial clock runs at `clk / (2*(div+1))`. Chip select goes active one full bit period before the first clock edge. After the last edge it stays active for a programmable number of cycles. A second programmable gap then keeps the block busy before it accepts the next write. Received bits land in a 128-bit receive word with the same frame layout as the transmit word. Three flags track progress: receive full, transmit empty, and a one-cycle transfer-complete pulse. An overrun flag protects unread receive data.

Top module: `spi_burst_master`

## Requirements
- R1: After synchronous reset, `cs_n` is 4'hF (while `cfg_cs_inv` is zero), `sclk`, `rx_full`, `overrun` and `xfer_done` are 0, `rx_data` is zero, and `tx_empty` is 1.
- R2: Each SCLK half period lasts `cfg_div+1` clock cycles. The first SCLK edge comes exactly `2*(cfg_div+1)` cycles after the chip select goes active.
- R3: While idle, SCLK follows `cfg_cpol` and settles one cycle after that input changes. During a transfer SCLK starts and ends at the latched polarity. With `cfg_cpha`=0, data is valid before the first edge and both sides sample on leading edges. With `cfg_cpha`=1, data changes on leading edges and both sides sample on trailing edges.
- R4: The frame length is `cfg_len_m1+1`; values below 7 act as 7. The frame count is `cfg_frames_m1+1`. Frame f occupies `wr_data[32*f +: length]`. All frames go out back to back in one chip-select window, using exactly `2*length*count` SCLK edges. Received bits land at the same positions in `rx_data`, and every other bit of `rx_data` is zero.
- R5: With `cfg_lsb_first`=0, each frame is sent and received from its highest bit down. With `cfg_lsb_first`=1, it goes from bit 0 up.
- R6: `cfg_cs_sel` picks one of four chip-select pins. The picked pin is driven low while active, or high if its `cfg_cs_inv` bit is set. Every other pin stays at its inactive level, which is the opposite of its active level.
- R7: The chip select goes inactive exactly `cfg_hold+1` cycles after the last SCLK edge.
- R8: `tx_empty` rises `cfg_gap+1` cycles after the chip select goes inactive. A `wr_en` pulse while `tx_empty` is low is ignored.
- R9: `xfer_done` pulses for one cycle, in the same cycle the chip select goes inactive. A receiving transfer sets `rx_full` at that point. `rd_en` clears `rx_full`.
- R10: `cfg_dir` selects the direction: 0 or 3 is full duplex, 1 is transmit-only, 2 is receive-only. A transmit-only transfer leaves `rx_data` and `rx_full` unchanged. A receive-only transfer holds MOSI at 0.
- R11: If a receiving transfer is accepted while `rx_full` is set, `overrun` is set, `rx_data` keeps its old contents, and `rx_full` stays set. `rd_en` clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_len_m1 | input | 5 | Frame length minus one |
| cfg_frames_m1 | input | 2 | Frame count minus one |
| cfg_div | input | 8 | Bit-rate divider |
| cfg_cs_sel | input | 2 | Chip-select pin index |
| cfg_cs_inv | input | 4 | Per-pin chip-select level invert |
| cfg_hold | input | 8 | Cycles from last edge to chip-select release, minus one |
| cfg_gap | input | 8 | Cycles from release to next acceptance, minus one |
| cfg_dir | input | 2 | Direction select |
| wr_en | input | 1 | Load transmit word and start |
| wr_data | input | 128 | Transmit frames |
| rd_en | input | 1 | Acknowledge receive word |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | 4 | Chip-select pins |
| rx_data | output | 128 | Received frames |
| rx_full | output | 1 | Receive word holds unread data |
| tx_empty | output | 1 | Ready to accept a write |
| xfer_done | output | 1 | Transfer-complete pulse |
| overrun | output | 1 | Receive data was not read in time |

## Verification
The bench runs six transfers that together cover all four clock modes, both bit orders, and frame lengths of 8, 13, 16, 20 and 32 bits with one to four frames. A slave model on the pins captures MOSI and drives MISO from a known stream. A wrong edge choice, a swapped bit order or a misplaced frame therefore shows up as a mismatch in both the captured word and the received word. Mixing divider, hold and gap values separates the setup time from the half period and the hold time from the gap. The transmit-only and receive-only runs are ordered so that one leaves an unread word behind and the next hits the overrun path. A write pulsed in the middle of a transfer checks that a busy block ignores writes.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    localparam int FRAME_W = 32;
    localparam int FRAMES  = 4;
    localparam int BUF_W   = FRAME_W * FRAMES;
    localparam int CS_N    = 4;
    localparam int DIV_W   = 8;
    localparam int DLY_W   = 8;
    localparam int MIN_LEN_M1 = 7;
    localparam int LEN_W   = $clog2(FRAME_W);
    localparam int FRM_W   = $clog2(FRAMES);
    localparam int SEL_W   = $clog2(CS_N);
    localparam int IDX_W   = $clog2(BUF_W);
    localparam int EDGE_W  = IDX_W + 1;

    typedef enum logic [1:0] {
        DIR_DUPLEX     = 2'd0,
        DIR_TX_ONLY    = 2'd1,
        DIR_RX_ONLY    = 2'd2,
        DIR_DUPLEX_ALT = 2'd3
    } dir_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP
    } seq_e;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic             lsb_first;
        logic [LEN_W-1:0] len_m1;
        logic [FRM_W-1:0] frames_m1;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] cs_sel;
        logic [DLY_W-1:0] hold;
        logic [DLY_W-1:0] gap;
        dir_e             dir;
    } xfer_cfg_t;

    function automatic logic dir_rx(dir_e d);
        return d != DIR_TX_ONLY;
    endfunction

    function automatic logic dir_tx(dir_e d);
        return d != DIR_RX_ONLY;
    endfunction

    // Index of the final SCLK edge: 2 * bits_per_frame * frames - 1
    function automatic logic [EDGE_W-1:0] final_edge(logic [LEN_W-1:0] l, logic [FRM_W-1:0] f);
        logic [EDGE_W:0] a;
        logic [EDGE_W:0] b;
        logic [EDGE_W:0] n;
        a = {{(EDGE_W+1-LEN_W){1'b0}}, l} + (EDGE_W+1)'(1);
        b = {{(EDGE_W+1-FRM_W){1'b0}}, f} + (EDGE_W+1)'(1);
        n = a * b;
        return EDGE_W'((n << 1) - (EDGE_W+1)'(1));
    endfunction
endpackage

// File: rtl/spi_burst_clkgen.sv
module spi_burst_clkgen
    import spi_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             shifting,
    input  logic [DIV_W-1:0] div,
    input  logic             idle_pol,
    output logic             tick,
    output logic             sclk
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else begin
            if (!run || tick) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
            if (!shifting)    sclk <= idle_pol;
            else if (tick)    sclk <= ~sclk;
        end
    end

    // R2: the half-period counter never passes the divider
    a_r2_half_period: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt_q <= div);
endmodule

// File: rtl/spi_burst_datapath.sv
module spi_burst_datapath
    import spi_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BUF_W-1:0] tx_word,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [FRM_W-1:0] frames_m1,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             edge_en,
    input  logic             miso,
    output logic             mosi,
    output logic [BUF_W-1:0] rx_word,
    output logic             last_edge
);
    logic [BUF_W-1:0]  tx_q;
    logic [LEN_W-1:0]  bit_q;
    logic [FRM_W-1:0]  frm_q;
    logic [EDGE_W-1:0] edge_q;
    logic [LEN_W-1:0]  phys;
    logic [IDX_W-1:0]  addr;
    logic              lead, smp, adv;

    always_comb begin
        phys = lsb_first ? bit_q : (len_m1 - bit_q);
        addr = {frm_q, phys};
        lead = ~edge_q[0];
        smp  = cpha ? ~lead : lead;
        adv  = cpha ? (lead && (edge_q != '0)) : ~lead;
    end

    assign mosi      = tx_en ? tx_q[addr] : 1'b0;
    assign last_edge = (edge_q == final_edge(len_m1, frames_m1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_word <= '0;
            bit_q   <= '0;
            frm_q   <= '0;
            edge_q  <= '0;
        end else if (load) begin
            tx_q    <= tx_word;
            rx_word <= '0;
            bit_q   <= '0;
            frm_q   <= '0;
            edge_q  <= '0;
        end else if (edge_en) begin
            edge_q <= edge_q + 1'b1;
            if (smp && rx_en) rx_word[addr] <= miso;
            if (adv) begin
                if (bit_q == len_m1) begin
                    bit_q <= '0;
                    frm_q <= frm_q + 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // R4: no edge is issued once the last frame has been consumed
    a_r4_frame_bound: assert property (@(posedge clk) disable iff (rst)
        edge_en |-> frm_q <= frames_m1);
    // R5: the bit pointer stays inside the frame
    a_r5_bit_bound: assert property (@(posedge clk) disable iff (rst)
        edge_en |-> bit_q <= len_m1);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [4:0]       cfg_len_m1,
    input  logic [1:0]       cfg_frames_m1,
    input  logic [7:0]       cfg_div,
    input  logic [1:0]       cfg_cs_sel,
    input  logic [3:0]       cfg_cs_inv,
    input  logic [7:0]       cfg_hold,
    input  logic [7:0]       cfg_gap,
    input  logic [1:0]       cfg_dir,
    input  logic             wr_en,
    input  logic [127:0]     wr_data,
    input  logic             rd_en,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic [3:0]       cs_n,
    output logic [127:0]     rx_data,
    output logic             rx_full,
    output logic             tx_empty,
    output logic             xfer_done,
    output logic             overrun
);
    seq_e             st_q;
    xfer_cfg_t        cfg_q, cfg_in;
    logic [DLY_W-1:0] dly_q;
    logic             keep_q;
    logic             tick, last_edge, edge_en, cs_on, run, idle_pol;
    logic [BUF_W-1:0] rx_word;

    always_comb begin
        cfg_in.cpol      = cfg_cpol;
        cfg_in.cpha      = cfg_cpha;
        cfg_in.lsb_first = cfg_lsb_first;
        cfg_in.len_m1    = (cfg_len_m1 < LEN_W'(MIN_LEN_M1)) ? LEN_W'(MIN_LEN_M1) : cfg_len_m1;
        cfg_in.frames_m1 = cfg_frames_m1;
        cfg_in.div       = cfg_div;
        cfg_in.cs_sel    = cfg_cs_sel;
        cfg_in.hold      = cfg_hold;
        cfg_in.gap       = cfg_gap;
        cfg_in.dir       = dir_e'(cfg_dir);
    end

    assign run      = (st_q == ST_SETUP) || (st_q == ST_SHIFT);
    assign edge_en  = tick && (st_q == ST_SHIFT);
    assign cs_on    = run || (st_q == ST_HOLD);
    assign tx_empty = (st_q == ST_IDLE);
    assign idle_pol = (st_q == ST_IDLE) ? cfg_cpol : cfg_q.cpol;

    spi_burst_clkgen u_clk (
        .clk(clk), .rst(rst), .run(run), .shifting(st_q == ST_SHIFT),
        .div(cfg_q.div), .idle_pol(idle_pol), .tick(tick), .sclk(sclk)
    );

    spi_burst_datapath u_dp (
        .clk(clk), .rst(rst), .load(wr_en && tx_empty), .tx_word(wr_data),
        .cpha(cfg_q.cpha), .lsb_first(cfg_q.lsb_first), .len_m1(cfg_q.len_m1),
        .frames_m1(cfg_q.frames_m1), .tx_en(dir_tx(cfg_q.dir)), .rx_en(dir_rx(cfg_q.dir)),
        .edge_en(edge_en), .miso(miso), .mosi(mosi), .rx_word(rx_word), .last_edge(last_edge)
    );

    for (genvar i = 0; i < CS_N; i++) begin : g_cs
        assign cs_n[i] = (cs_on && (cfg_q.cs_sel == SEL_W'(i))) ? cfg_cs_inv[i] : ~cfg_cs_inv[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cfg_q     <= '0;
            dly_q     <= '0;
            keep_q    <= 1'b0;
            rx_data   <= '0;
            rx_full   <= 1'b0;
            overrun   <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (rd_en) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            case (st_q)
                ST_IDLE: if (wr_en) begin
                    cfg_q  <= cfg_in;
                    st_q   <= ST_SETUP;
                    keep_q <= rx_full && !rd_en;
                    if (rx_full && !rd_en && dir_rx(cfg_in.dir)) overrun <= 1'b1;
                end
                ST_SETUP: if (tick) st_q <= ST_SHIFT;
                ST_SHIFT: if (tick && last_edge) begin
                    st_q  <= ST_HOLD;
                    dly_q <= cfg_q.hold;
                end
                ST_HOLD: if (dly_q == '0) begin
                    st_q      <= ST_GAP;
                    dly_q     <= cfg_q.gap;
                    xfer_done <= 1'b1;
                    if (dir_rx(cfg_q.dir) && !keep_q) begin
                        rx_data <= rx_word;
                        rx_full <= 1'b1;
                    end
                end else begin
                    dly_q <= dly_q - 1'b1;
                end
                ST_GAP: if (dly_q == '0) st_q <= ST_IDLE;
                        else             dly_q <= dly_q - 1'b1;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R6: never more than one chip-select pin at its active level
    a_r6_single_cs: assert property (@(posedge clk) disable iff (rst)
        $countones(cs_n ^ ~cfg_cs_inv) <= 1);
    // R3: clock sits at the latched polarity once shifting ends
    a_r3_rest_level: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD || st_q == ST_GAP) |-> sclk == cfg_q.cpol);
    // R2: no clock edge inside the setup bit period
    a_r2_setup_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETUP && $past(st_q) == ST_SETUP) |-> $stable(sclk));
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);
    // R11: raising overrun never disturbs held receive data
    a_r11_keep_old: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $stable(rx_data));
    // R10: receive-only transfers keep MOSI low
    a_r10_quiet_mosi: assert property (@(posedge clk) disable iff (rst)
        (cs_on && cfg_q.dir == DIR_RX_ONLY) |-> !mosi);
endmodule

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
    import spi_burst_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    logic cfg_cpol, cfg_cpha, cfg_lsb_first;
    logic [4:0] cfg_len_m1;
    logic [1:0] cfg_frames_m1, cfg_cs_sel, cfg_dir;
    logic [7:0] cfg_div, cfg_hold, cfg_gap;
    logic [3:0] cfg_cs_inv;
    logic wr_en, rd_en, miso;
    logic [127:0] wr_data;
    logic sclk, mosi, rx_full, tx_empty, xfer_done, overrun;
    logic [3:0] cs_n;
    logic [127:0] rx_data;

    spi_burst_master dut_i (.*);

    int checks = 0, fails = 0;
    logic [127:0] exp_q[$];

    // slave model and timing monitor state
    logic c_cpol = 1'b0, c_cpha = 1'b0;
    int   c_sel = 0, c_div = 0;
    logic [127:0] s_miso = '0, s_cap = '0;
    int   s_k, s_m, n_edges, t_act, t_first, t_last, t_rel, t_idle, cyc = 0;
    int   spacing_bad, other_bad;
    logic rel_done, cs_act, cs_prev = 1'b0, sclk_prev = 1'b0, te_prev = 1'b1;

    // model of status
    logic m_full = 1'b0, m_ovr = 1'b0;
    logic [127:0] m_rx = '0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            miso = 1'b0;
            cs_prev = 1'b0;
        end else begin
            cs_act = (cs_n[c_sel] == cfg_cs_inv[c_sel]);
            if (cs_act) begin
                for (int j = 0; j < 4; j++)
                    if (j != c_sel && cs_n[j] != ~cfg_cs_inv[j]) other_bad++;
            end
            if (cs_act && !cs_prev) begin
                t_act = cyc; n_edges = 0; s_k = 0; s_m = 0; s_cap = '0;
                spacing_bad = 0; other_bad = 0;
                miso = s_miso[0];
            end
            if (cs_act && sclk != sclk_prev) begin
                logic lead;
                lead = (sclk_prev == c_cpol);
                if (n_edges == 0) t_first = cyc;
                else if (cyc - t_last != c_div + 1) spacing_bad++;
                t_last = cyc;
                n_edges++;
                if (lead ^ c_cpha) begin
                    if (s_k < 128) s_cap[s_k] = mosi;
                    s_k++;
                end
                if (c_cpha && lead) begin
                    if (s_m < 128) miso = s_miso[s_m];
                    s_m++;
                end else if (!c_cpha && !lead) begin
                    s_m++;
                    if (s_m < 128) miso = s_miso[s_m];
                end
            end
            if (!cs_act && cs_prev) begin
                t_rel = cyc;
                rel_done = xfer_done;
            end
            if (tx_empty && !te_prev) t_idle = cyc;
            if (xfer_done) begin
                if (exp_q.size() == 0) chk(0, "R9 unexpected completion", 1, 0);
                else begin
                    logic [127:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R4 scoreboard rx_data", rx_data, e);
                end
            end
            sclk_prev = sclk; cs_prev = cs_act; te_prev = tx_empty;
        end
    end

    task automatic xfer(input logic pol, input logic pha, input logic lsb, input int len, input int nfr,
                        input int div, input int sel, input logic [3:0] inv, input int hold, input int gap,
                        input int dir, input logic [127:0] tx, input logic [127:0] mi, input bit poke,
                        input string tag);
        logic [127:0] exp_mosi, exp_rx;
        bit rx_on;
        int k, wait_n;
        exp_mosi = '0; exp_rx = '0; k = 0;
        rx_on = (dir != 1);
        for (int f = 0; f < nfr; f++) begin
            for (int i = 0; i < len; i++) begin
                int phys;
                phys = lsb ? i : len - 1 - i;
                exp_mosi[k] = (dir == 2) ? 1'b0 : tx[f*32 + phys];
                exp_rx[f*32 + phys] = mi[k];
                k++;
            end
        end
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
        cfg_len_m1 = 5'(len - 1); cfg_frames_m1 = 2'(nfr - 1); cfg_div = 8'(div);
        cfg_cs_sel = 2'(sel); cfg_cs_inv = inv; cfg_hold = 8'(hold); cfg_gap = 8'(gap);
        cfg_dir = 2'(dir);
        c_cpol = pol; c_cpha = pha; c_sel = sel; c_div = div; s_miso = mi;
        @(negedge clk);
        @(negedge clk);
        if (rx_on && !m_full) exp_q.push_back(exp_rx);
        else                  exp_q.push_back(m_rx);
        if (rx_on && m_full) m_ovr = 1'b1;
        wr_en = 1'b1; wr_data = tx;
        @(negedge clk);
        wr_en = 1'b0;
        wait_n = 0;
        do begin
            @(negedge clk);
            wait_n++;
            if (poke && wait_n == 5) begin
                wr_en = 1'b1; wr_data = ~tx;
            end else begin
                wr_en = 1'b0;
            end
        end while (!tx_empty && wait_n < 20000);
        wr_en = 1'b0;
        #1;
        chk(s_cap == exp_mosi, {tag, " R3 R5 mosi stream"}, s_cap, exp_mosi);
        chk(n_edges == 2*len*nfr, {tag, " R4 edge count"}, 128'(n_edges), 128'(2*len*nfr));
        chk(t_first - t_act == 2*(div+1), {tag, " R2 setup time"}, 128'(t_first - t_act), 128'(2*(div+1)));
        chk(spacing_bad == 0, {tag, " R2 half period"}, 128'(spacing_bad), 0);
        chk(other_bad == 0, {tag, " R6 other pins inactive"}, 128'(other_bad), 0);
        chk(t_rel - t_last == hold + 1, {tag, " R7 hold delay"}, 128'(t_rel - t_last), 128'(hold + 1));
        chk(t_idle - t_rel == gap + 1, {tag, " R8 gap delay"}, 128'(t_idle - t_rel), 128'(gap + 1));
        chk(rel_done == 1'b1, {tag, " R9 done at release"}, 128'(rel_done), 1);
        if (rx_on && !m_full) begin
            m_rx = exp_rx; m_full = 1'b1;
        end
        chk(rx_full == m_full, {tag, " R9 R10 rx_full"}, 128'(rx_full), 128'(m_full));
        chk(overrun == m_ovr, {tag, " R11 overrun"}, 128'(overrun), 128'(m_ovr));
        if (poke) begin
            repeat (20) @(negedge clk);
            #1;
            chk(tx_empty && cs_n == ~inv, {tag, " R8 busy write ignored"}, {tx_empty, cs_n}, {1'b1, ~inv});
        end
    endtask

    task automatic read_rx();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        m_full = 1'b0; m_ovr = 1'b0;
        chk(!rx_full, "R9 rd_en clears rx_full", 128'(rx_full), 0);
        chk(!overrun, "R11 rd_en clears overrun", 128'(overrun), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_len_m1 = 5'd7; cfg_frames_m1 = 0;
        cfg_div = 0; cfg_cs_sel = 0; cfg_cs_inv = 0; cfg_hold = 0; cfg_gap = 0; cfg_dir = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(cs_n == 4'hF && sclk == 0 && tx_empty && !rx_full && !overrun && !xfer_done,
            "R1 reset outputs", {cs_n, sclk, tx_empty, rx_full, overrun, xfer_done}, {4'hF, 5'b01000});
        chk(rx_data == '0, "R1 reset rx_data", rx_data, '0);

        // R3 idle level follows polarity
        cfg_cpol = 1'b1;
        @(negedge clk); #1;
        chk(sclk == 1'b1, "R3 idle high", 128'(sclk), 1);
        cfg_cpol = 1'b0;
        @(negedge clk); #1;
        chk(sclk == 1'b0, "R3 idle low", 128'(sclk), 0);

        xfer(0, 0, 0, 8, 1, 1, 0, 4'b0000, 2, 3, 0,
             128'h5A, 128'h1C3, 1, "T1 mode0");
        read_rx();
        xfer(1, 1, 1, 32, 4, 0, 2, 4'b0100, 0, 0, 0,
             128'hDEADBEEF_01234567_89ABCDEF_F00DCAFE, 128'h96E1_3C5A_0FF0_A55A_C3C3_7E81_1248_BD24,
             0, "T2 mode3");
        read_rx();
        xfer(0, 1, 0, 13, 3, 3, 1, 4'b0000, 5, 1, 3,
             128'h00001ABC_00000F0F_00001555, 128'h7_3A5C_E1B2_9D4F, 0, "T3 mode1");
        xfer(1, 0, 1, 20, 2, 2, 3, 4'b1001, 1, 2, 1,
             128'h000ABCDE_00012345, 128'hFF_FFFF_FFFF, 0, "T4 mode2 tx-only R10");
        xfer(0, 0, 0, 8, 2, 0, 0, 4'b0000, 0, 0, 2,
             128'hFFFF, 128'hA5C3, 0, "T5 rx-only overrun R11");
        read_rx();
        xfer(1, 1, 0, 16, 1, 1, 1, 4'b0000, 3, 0, 2,
             128'hFFFF, 128'h8E71, 0, "T6 rx-only R10");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all completions seen", 128'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule